// File: doc/BRIEF.md
# Write Precompensation Pattern Detector

This block watches the serial run-length-limited code stream on its way to the write head, one code bit per clock. Every code bit equal to one is judged against the code bits on both sides of it. The block then decides whether that pulse must be moved earlier or later in time, and whether the smaller shift for 3T neighbour spacing applies instead of the full shift for 2T spacing. Three flags come out of the block, registered together with a delayed copy of the code bit they describe. A downstream analog delay stage can take a flag and its code bit together.

The window holds four code bits before the target and three after it. A target is judged only if it is isolated: no one directly after it, and none in the two positions before it. A near neighbour on one side only, with the other side empty, decides the direction of the shift. The distance to that neighbour decides the level. When the 3T level is disabled, one level is used for everything: the level flag stays low and the direction is still reported. When the bypass input is high, the code bit is passed on after a single register and all flags are held low.

Top module: `pcmp_detect`

## Requirements
- R1: While rst_n is low, code_out, early, late and lvl3t are all 0, and the window of past code bits reads as all zeros afterwards.
- R2: With bypass low, code_out equals the code_in value sampled five rising edges earlier, counting the edge that updates code_out (a latency of 4 clock periods after the sampling edge).
- R3: For a target one with ones at distance 3 before it, zeros at distances 1 and 2 before it, and zeros at all three positions after it, early is 1, and late and lvl3t are 0.
- R4: For a target one whose nearest earlier one is at distance 4, with zeros after it, early and lvl3t are 1 and late is 0 when cfg_3t_en is 1.
- R5: For a target one with no ones in the four positions before it, a zero directly after it and a one two positions after it, late is 1, and early and lvl3t are 0.
- R6: For a target one with no ones before it, whose nearest later one is three positions after it, late and lvl3t are 1 and early is 0 when cfg_3t_en is 1.
- R7: A target one with a neighbour inside the window on both sides, or on neither side, gives all three flags 0.
- R8: A target code bit of 0, or a target one with a one at distance 1 or 2 before it or at distance 1 after it, gives all three flags 0.
- R9: With cfg_3t_en low, lvl3t is 0, and early and late follow R3 to R6 unchanged.
- R10: With bypass high at a rising edge, code_out after that edge equals code_in sampled at that edge, and all three flags are 0.
- R11: early and late are never 1 together, and lvl3t is 1 only when one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-rate clock, one code bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 1 | Serial code bit from the encoder |
| cfg_3t_en | input | 1 | 1 enables the reduced 3T level flag |
| bypass | input | 1 | 1 skips precompensation: short path, flags low |
| code_out | output | 1 | Code bit aligned with the flags |
| early | output | 1 | Shift this pulse earlier |
| late | output | 1 | Shift this pulse later |
| lvl3t | output | 1 | Reduced (3T) shift amount applies |

## Verification
The checker assumes that code_in, cfg_3t_en and bypass change only between rising edges. It also assumes that code_in is held at 0 while reset is asserted, so the first window after reset holds only zeros. The stimulus is driven on falling edges and keeps code_in low during reset. It then feeds directed isolated-pulse patterns for each spacing case. Random streams follow, including streams that break the run-length constraint, while the 3T enable and the bypass are switched mid-stream, so that windows straddling a mode change are also compared.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  // Window geometry fixed by the decision rules: bits before and after target
  localparam int PRE_DEPTH  = 4;
  localparam int POST_DEPTH = 3;
  localparam int WIN_LEN    = PRE_DEPTH + 1 + POST_DEPTH;
  localparam int TGT_IDX    = POST_DEPTH;   // index 0 is the newest bit

  typedef struct packed {
    logic early;
    logic late;
    logic lvl3t;
  } pc_flags_t;

  // Position helpers: distance k before / after the target inside the window
  function automatic int pre_pos(input int k);
    return TGT_IDX + k;
  endfunction

  function automatic int post_pos(input int k);
    return TGT_IDX - k;
  endfunction

  // Decision for the bit sitting at TGT_IDX
  function automatic pc_flags_t classify(input logic [WIN_LEN-1:0] w,
                                         input logic en3t);
    pc_flags_t res;
    logic pre_any;
    logic post_any;
    res      = '0;
    pre_any  = 1'b0;
    post_any = 1'b0;
    for (int k = 1; k <= PRE_DEPTH; k++)  pre_any  = pre_any  | w[pre_pos(k)];
    for (int k = 1; k <= POST_DEPTH; k++) post_any = post_any | w[post_pos(k)];
    if (w[TGT_IDX] && !w[pre_pos(1)] && !w[pre_pos(2)] && !w[post_pos(1)]) begin
      if (pre_any && !post_any) begin
        res.early = 1'b1;
        res.lvl3t = en3t & ~w[pre_pos(3)];
      end else if (post_any && !pre_any) begin
        res.late  = 1'b1;
        res.lvl3t = en3t & ~w[post_pos(2)];
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/pcmp_window.sv
module pcmp_window
  import pcmp_pkg::*;
#(
  parameter int LEN = WIN_LEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] win
);

  logic [LEN-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= din;
  end

  for (genvar g = 1; g < LEN; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign win = stage_q;

endmodule

// File: rtl/pcmp_classify.sv
module pcmp_classify
  import pcmp_pkg::*;
(
  input  logic [WIN_LEN-1:0] win,
  input  logic               en3t,
  output logic               tgt_bit,
  output pc_flags_t          flags
);

  assign tgt_bit = win[TGT_IDX];

  always_comb begin
    flags = classify(win, en3t);
  end

endmodule

// File: rtl/pcmp_align.sv
module pcmp_align
  import pcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bypass,
  input  logic      raw_bit,
  input  logic      tgt_bit,
  input  pc_flags_t flags_in,
  output logic      code_q,
  output pc_flags_t flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 1'b0;
      flags_q <= '0;
    end else if (bypass) begin
      code_q  <= raw_bit;
      flags_q <= '0;
    end else begin
      code_q  <= tgt_bit;
      flags_q <= flags_in;
    end
  end

endmodule

// File: rtl/pcmp_detect.sv
module pcmp_detect
  import pcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic code_in,
  input  logic cfg_3t_en,
  input  logic bypass,
  output logic code_out,
  output logic early,
  output logic late,
  output logic lvl3t
);

  logic [WIN_LEN-1:0] win;
  logic               tgt_bit;
  pc_flags_t          dec_flags;
  pc_flags_t          out_flags;

  pcmp_window #(.LEN(WIN_LEN)) i_window (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (code_in),
    .win   (win)
  );

  pcmp_classify i_classify (
    .win     (win),
    .en3t    (cfg_3t_en),
    .tgt_bit (tgt_bit),
    .flags   (dec_flags)
  );

  pcmp_align i_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (bypass),
    .raw_bit  (code_in),
    .tgt_bit  (tgt_bit),
    .flags_in (dec_flags),
    .code_q   (code_out),
    .flags_q  (out_flags)
  );

  assign early = out_flags.early;
  assign late  = out_flags.late;
  assign lvl3t = out_flags.lvl3t;

endmodule

// File: rtl/pcmp_detect_chk.sv
module pcmp_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic code_in,
  input logic cfg_3t_en,
  input logic bypass,
  input logic code_out,
  input logic early,
  input logic late,
  input logic lvl3t
);

  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!code_out && !early && !late && !lvl3t));

  a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(early && late));

  a_r11_level_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
    lvl3t |-> (early || late));

  a_r9_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_3t_en |=> !lvl3t);

  a_r10_bypass_flags: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (!early && !late && !lvl3t));

  a_r10_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (code_out == $past(code_in)));

  a_r2_target_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (early || late) |-> code_out);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd7 && !bypass) |=> (code_out == $past(code_in, 5)));

endmodule

bind pcmp_detect pcmp_detect_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .code_in   (code_in),
  .cfg_3t_en (cfg_3t_en),
  .bypass    (bypass),
  .code_out  (code_out),
  .early     (early),
  .late      (late),
  .lvl3t     (lvl3t)
);

// File: tb/test_pcmp_detect.sv
module test_pcmp_detect;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_in = 1'b0;
  logic cfg_3t_en = 1'b1;
  logic bypass = 1'b0;
  logic code_out, early, late, lvl3t;

  int checks = 0;
  int failures = 0;
  int hist[$];
  bit exp_code, exp_e, exp_l, exp_p;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcmp_detect i_pcmp_detect (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .cfg_3t_en(cfg_3t_en),
    .bypass(bypass), .code_out(code_out), .early(early), .late(late),
    .lvl3t(lvl3t)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference: hist[0] is the bit taken at the latest edge
  task automatic model(input bit cin, input bit en, input bit byp);
    int db, da, t;
    hist.push_front(cin);
    while (hist.size() > 12) void'(hist.pop_back());
    exp_e = 0; exp_l = 0; exp_p = 0;
    if (byp) begin
      exp_code = cin; exp_tag = "R10"; return;
    end
    t = hist[4];
    exp_code = t[0];
    db = 0; da = 0;
    for (int k = 4; k >= 1; k--) if (hist[4+k] == 1) db = k;
    for (int k = 3; k >= 1; k--) if (hist[4-k] == 1) da = k;
    if (t == 0 || db == 1 || db == 2 || da == 1) begin exp_tag = "R8"; return; end
    if ((db != 0) == (da != 0)) begin exp_tag = "R7"; return; end
    if (db == 3) begin exp_e = 1; exp_tag = "R3"; end
    if (db == 4) begin exp_e = 1; exp_p = en; exp_tag = "R4"; end
    if (da == 2) begin exp_l = 1; exp_tag = "R5"; end
    if (da == 3) begin exp_l = 1; exp_p = en; exp_tag = "R6"; end
    if (!en) exp_tag = "R9";
  endtask

  task automatic step(input bit cin, input bit en, input bit byp);
    code_in = cin; cfg_3t_en = en; bypass = byp;
    @(posedge clk);
    model(cin, en, byp);
    @(negedge clk);
    check(byp ? "R10" : "R2", "code_out", code_out, exp_code);
    check(exp_tag, "early", early, exp_e);
    check(exp_tag, "late", late, exp_l);
    check(exp_tag, "lvl3t", lvl3t, exp_p);
    check("R11", "both_dirs", early & late, 0);
  endtask

  task automatic send(input logic [31:0] bits, input int n, input bit en, input bit byp);
    for (int i = n - 1; i >= 0; i--) step(bits[i], en, byp);
  endtask

  task automatic directed(input bit en, input bit byp);
    send(32'b0000_1001_0000_0000, 16, en, byp);    // late 3T then early full
    send(32'b0000_1000_1000_0000, 16, en, byp);    // far neighbour then early 3T
    send(32'b0000_1010_0000_0000, 16, en, byp);    // late full then adjacency
    send(32'b0001_0010_0100_0000, 16, en, byp);    // both-side neighbours
    send(32'b0000_0110_0000_0000, 16, en, byp);    // adjacent ones
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) hist.push_back(0);
    repeat (3) @(negedge clk);
    check("R1", "code_out", code_out, 0);
    check("R1", "early", early, 0);
    check("R1", "late", late, 0);
    check("R1", "lvl3t", lvl3t, 0);
    rst_n = 1'b1;
    directed(1'b1, 1'b0);
    directed(1'b0, 1'b0);
    directed(1'b1, 1'b1);
    send(32'h0, 10, 1'b1, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      bit b, en, byp;
      b   = (i % 1000 < 600) ? (($urandom % 3) == 0) : $urandom % 2;
      en  = (($urandom % 8) != 0);
      byp = (i % 400 > 370);
      step(b, en, byp);
    end
    // Reset mid-stream, then check the window was cleared
    send(32'hFF, 8, 1'b1, 1'b0);
    rst_n = 1'b0;
    code_in = 1'b0;
    @(negedge clk);
    check("R1", "code_out", code_out, 0);
    check("R1", "early", early, 0);
    for (int i = 0; i < 12; i++) hist[i] = 0;
    rst_n = 1'b1;
    send(32'b0000_1001_0000, 12, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule